// File: doc/BRIEF.md
# Multi-timer interrupt status and clear

This block holds four independent 32-bit down-counting timers and manages the interrupt each one raises. A running timer counts down by one every clock. When it steps from one to zero it sets a sticky "expired" flag. On the next edge it reloads from its reload register and starts counting again. The four flags sit in one shared control/status word. Each flag is gated by its own interrupt-enable bit, and the gated flags are ORed onto a single interrupt line.

Software reaches the block through a simple memory-mapped bus with one-cycle write strobes and one-cycle read strobes. A flag can be cleared in two ways. The first is a write of any data to that timer's dedicated clear address. The second is a write of 0 to the flag's bit in the status word. Each timer's count can be read back. A mode bit chooses what a count read returns: the live count, or a snapshot of all four counts taken when the status word is read. The snapshot lets software read several counts that belong to the same instant.

Top module: `tmr_irq_hub`

## Requirements
- R1: Byte address 0x10+4k (k = 0..3 for timers 1..4) is readable and writable. A write loads both the reload value and the count of timer k+1. While its run bit is 1, a timer with a non-zero count decrements by one per clock, and a timer at zero reloads from its reload value. While its run bit is 0, the count holds.
- R2: On the clock edge where a running timer has count 1, its expired flag becomes 1. The flag stays 1 until software clears it.
- R3: A write of any data to byte address 0x30+4k clears the expired flag of timer k+1, on the same edge, and leaves the other flags unchanged.
- R4: A write to the status word at address 0x00 clears each expired flag whose bit in the written data is 0. A bit written as 1 leaves its flag unchanged and never sets it.
- R5: If an expiry and either kind of clear for the same timer fall on the same edge, the flag ends up 1.
- R6: `irq` is 1 exactly when some timer has both its expired flag and its interrupt-enable bit at 1. It follows the flags and enables with no added cycle of delay.
- R7: The status word at 0x00 has this layout: run bits [3:0], interrupt enables [7:4], expired flags [11:8] (read, or write-0-to-clear), count-read mode [16], all other bits 0. After reset every field is 0 and `irq` is 0. Read data appears on `rdata` in the cycle after `rd_en`, and `rdata` is 0 in any cycle that does not follow a read.
- R8: In mode 0, a read of byte address 0x20+4k returns the count of timer k+1 as it stood in the read cycle.
- R9: In mode 1, each read of the status word captures all four counts on the same edge. Reads of 0x20+4k return the captured value until the next status read, however the live counts move.
- R10: Reads of the clear addresses 0x30 to 0x3C return 0.
- R11: A running timer whose reload value is 0 stays at 0 once it reaches 0 and raises no further expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle after rd_en |
| irq | output | 1 | Combined interrupt |

## Verification
A timer expiry and a software clear of the same flag can fall on one edge, and by either clear path. The bench provokes this by watching its own model's count and issuing the clear write in the exact cycle the count is 1. It does this once through the dedicated clear address and once through a write of 0 to the status word. It then judges the result from the next status read and from `irq`, both of which must still show the flag set. A status read that captures counts in mode 1 while the timers keep running is also compared against the model, to show that the snapshot holds.

// File: rtl/tih_pkg.sv
`timescale 1ns/1ps
// Package tih_pkg
// Shared address map, status-word field positions and address helper for
// the multi-timer interrupt hub. Assumes at most four timers, 4-bit fields.
package tih_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int RLD_BASE = 'h10;
    localparam int CNT_BASE = 'h20;
    localparam int CLR_BASE = 'h30;
    localparam int RUN_LSB  = 0;
    localparam int IEN_LSB  = 4;
    localparam int FLG_LSB  = 8;
    localparam int MODE_BIT = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam addr_t STAT_ADDR = addr_t'(0);

    // Byte address of the per-timer slot idx in the group starting at base.
    function automatic addr_t slot_addr(input int base, input int idx);
        return addr_t'(base + 4 * idx);
    endfunction
endpackage

// File: rtl/tih_timer.sv
`timescale 1ns/1ps
// Module tih_timer
// One down-counting timer with its reload register. A load writes both the
// count and the reload value. When running, the count decrements and reloads
// at zero. expire is high in the cycle the running count is one.
// Assumes load and run come from registered control in the parent.
module tih_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] rld_q;

    // Count register: a load wins over counting; reload when at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            rld_q <= load_val;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? rld_q : cnt_q - ONE;
        end
    end

    assign expire = run && (cnt_q == ONE);
    assign count  = cnt_q;
    assign reload = rld_q;
endmodule

// File: rtl/tih_flags.sv
`timescale 1ns/1ps
// Module tih_flags
// Sticky expired flags with two clear paths and the combined interrupt.
// The status-word write keeps only flags written as 1, clear-address hits
// clear single flags, and an expiry in the same cycle overrides both.
// Assumes all inputs are single-cycle qualified strobes from the parent.
module tih_flags #(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] expire,
    input  logic               stat_wr,
    input  logic [NUM_TMR-1:0] stat_keep,
    input  logic [NUM_TMR-1:0] clr_hit,
    input  logic [NUM_TMR-1:0] ien,
    output logic [NUM_TMR-1:0] flags,
    output logic               irq
);
    logic [NUM_TMR-1:0] flg_q;
    logic [NUM_TMR-1:0] flg_nxt;

    // Next flags: apply both clear paths, then let expiries set.
    always_comb begin
        flg_nxt = flg_q;
        if (stat_wr) begin
            flg_nxt = flg_nxt & stat_keep;
        end
        flg_nxt = (flg_nxt & ~clr_hit) | expire;
    end

    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_nxt;
        end
    end

    assign flags = flg_q;
    assign irq   = |(flg_q & ien);
endmodule

// File: rtl/tih_snap.sv
`timescale 1ns/1ps
// Module tih_snap
// Count readback view. In mode 0 the live counts pass through; in mode 1
// the counts captured at the last capture strobe are shown instead.
// Assumes capture is a single-cycle strobe (a status-word read).
module tih_snap #(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic                     mode,
    input  logic [NUM_TMR*CNT_W-1:0] live,
    output logic [NUM_TMR*CNT_W-1:0] view
);
    logic [NUM_TMR*CNT_W-1:0] shadow_q;

    // Snapshot register: all counts taken together on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (capture) begin
            shadow_q <= live;
        end
    end

    assign view = mode ? shadow_q : live;
endmodule

// File: rtl/tmr_irq_hub.sv
`timescale 1ns/1ps
// Module tmr_irq_hub
// Register-mapped hub for NUM_TMR down-counting timers: address decode,
// control bits, timers, sticky flags with two clear paths, the combined
// interrupt and registered read data. Assumes NUM_TMR <= 4, CNT_W <= 32,
// and that wr_en and rd_en are never high in the same cycle.
module tmr_irq_hub
    import tih_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int FLAT_W = NUM_TMR * CNT_W;

    logic [NUM_TMR-1:0] run_q;
    logic [NUM_TMR-1:0] ien_q;
    logic               mode_q;
    logic [NUM_TMR-1:0] ld_hit;
    logic [NUM_TMR-1:0] clr_hit;
    logic [NUM_TMR-1:0] exp_v;
    logic [NUM_TMR-1:0] flg_v;
    logic [FLAT_W-1:0]  cnt_flat;
    logic [FLAT_W-1:0]  rld_flat;
    logic [FLAT_W-1:0]  view_flat;
    logic               stat_wr;
    logic               stat_rd;
    word_t              rd_nxt;
    word_t              rdata_q;

    assign stat_wr = wr_en && (addr == STAT_ADDR);
    assign stat_rd = rd_en && (addr == STAT_ADDR);

    // Control bits: run, interrupt enables and count-read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            ien_q  <= '0;
            mode_q <= 1'b0;
        end else if (stat_wr) begin
            run_q  <= wdata[RUN_LSB +: NUM_TMR];
            ien_q  <= wdata[IEN_LSB +: NUM_TMR];
            mode_q <= wdata[MODE_BIT];
        end
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        assign ld_hit[i]  = wr_en && (addr == slot_addr(RLD_BASE, i));
        assign clr_hit[i] = wr_en && (addr == slot_addr(CLR_BASE, i));

        tih_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[i]),
            .load     (ld_hit[i]),
            .load_val (wdata[CNT_W-1:0]),
            .count    (cnt_flat[i*CNT_W +: CNT_W]),
            .reload   (rld_flat[i*CNT_W +: CNT_W]),
            .expire   (exp_v[i])
        );
    end

    tih_flags #(.NUM_TMR(NUM_TMR)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (exp_v),
        .stat_wr   (stat_wr),
        .stat_keep (wdata[FLG_LSB +: NUM_TMR]),
        .clr_hit   (clr_hit),
        .ien       (ien_q),
        .flags     (flg_v),
        .irq       (irq)
    );

    tih_snap #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (stat_rd),
        .mode    (mode_q),
        .live    (cnt_flat),
        .view    (view_flat)
    );

    // Read mux: status word, reload values, count view; all else reads 0.
    always_comb begin
        rd_nxt = '0;
        if (addr == STAT_ADDR) begin
            rd_nxt[RUN_LSB +: NUM_TMR] = run_q;
            rd_nxt[IEN_LSB +: NUM_TMR] = ien_q;
            rd_nxt[FLG_LSB +: NUM_TMR] = flg_v;
            rd_nxt[MODE_BIT]           = mode_q;
        end
        for (int i = 0; i < NUM_TMR; i++) begin
            if (addr == slot_addr(RLD_BASE, i)) begin
                rd_nxt = DATA_W'(rld_flat[i*CNT_W +: CNT_W]);
            end
            if (addr == slot_addr(CNT_BASE, i)) begin
                rd_nxt = DATA_W'(view_flat[i*CNT_W +: CNT_W]);
            end
        end
    end

    // Read data register: valid the cycle after a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_en ? rd_nxt : '0;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/tmr_irq_hub_chk.sv
`timescale 1ns/1ps
// Module tmr_irq_hub_chk
// Property checker bound into tmr_irq_hub. It relates bus strobes, timer
// expiries, the flag register, the enables and the interrupt over time.
// Assumes the same NUM_TMR as the bound instance.
module tmr_irq_hub_chk
    import tih_pkg::*;
#(
    parameter int NUM_TMR = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [NUM_TMR-1:0] wflg,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_TMR-1:0] flags,
    input logic [NUM_TMR-1:0] expire,
    input logic [NUM_TMR-1:0] ien,
    input logic               irq
);
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        assert_flag_on_expiry_R2: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> flags[i]);

        assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(wr_en && (addr == STAT_ADDR || addr == slot_addr(CLR_BASE, i))))
            |=> flags[i]);

        assert_addr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == slot_addr(CLR_BASE, i) && !expire[i]) |=> !flags[i]);

        assert_write_one_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == STAT_ADDR && wflg[i] && !flags[i] && !expire[i]) |=> !flags[i]);

        assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && expire[i] && (addr == STAT_ADDR || addr == slot_addr(CLR_BASE, i)))
            |=> flags[i]);

        assert_clear_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == slot_addr(CLR_BASE, i)) |=> (rdata == '0));
    end

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags));

    assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ien) |-> !irq);
endmodule

bind tmr_irq_hub tmr_irq_hub_chk #(.NUM_TMR(NUM_TMR)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wflg   (wdata[tih_pkg::FLG_LSB +: NUM_TMR]),
    .rdata  (rdata),
    .flags  (flg_v),
    .expire (exp_v),
    .ien    (ien_q),
    .irq    (irq)
);

// File: tb/tmr_irq_hub_tb_top.sv
`timescale 1ns/1ps
// Bench for tmr_irq_hub: a behavioural per-cycle model, compared every clock.
module tmr_irq_hub_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_tag = "R7";

    logic [31:0] m_cnt [4];
    logic [31:0] m_rld [4];
    logic [31:0] m_shd [4];
    logic [3:0]  m_run = '0, m_ien = '0, m_flg = '0;
    logic        m_mode = 1'b0;
    logic [31:0] m_rdata = '0;

    tmr_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL R1 watchdog actual %0d cycles expected fewer", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // One clock of the reference model, from the state before the edge.
    task automatic model_edge(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
        logic [3:0]  ex;
        logic [3:0]  f;
        logic [31:0] rd;
        for (int i = 0; i < 4; i++) ex[i] = m_run[i] && (m_cnt[i] == 32'd1);
        rd = '0;
        if (r) begin
            if (a == 8'h00) begin
                rd = {15'b0, m_mode, 4'b0, m_flg, m_ien, m_run};
            end
            for (int i = 0; i < 4; i++) begin
                if (a == 8'(16 + 4 * i)) rd = m_rld[i];
                if (a == 8'(32 + 4 * i)) rd = m_mode ? m_shd[i] : m_cnt[i];
            end
            if (a == 8'h00) for (int i = 0; i < 4; i++) m_shd[i] = m_cnt[i];
        end
        m_rdata = rd;
        for (int i = 0; i < 4; i++) begin
            if (w && a == 8'(16 + 4 * i)) begin
                m_cnt[i] = d;
                m_rld[i] = d;
            end else if (m_run[i]) begin
                m_cnt[i] = (m_cnt[i] == 0) ? m_rld[i] : m_cnt[i] - 1;
            end
        end
        f = m_flg;
        if (w && a == 8'h00) f = f & d[11:8];
        for (int i = 0; i < 4; i++) if (w && a == 8'(48 + 4 * i)) f[i] = 1'b0;
        m_flg = f | ex;
        if (w && a == 8'h00) begin
            m_run = d[3:0];
            m_ien = d[7:4];
            m_mode = d[16];
        end
    endtask

    task automatic step(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(posedge clk);
        model_edge(w, r, a, d);
        @(negedge clk);
        chk("R6 irq", {31'b0, irq}, {31'b0, |(m_flg & m_ien)});
        chk(cur_tag, rdata, m_rdata);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = '0; m_rld[i] = '0; m_shd[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        chk("R7 reset irq", {31'b0, irq}, 32'h0);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R7 reset status", rdata, 32'h0);
        idle(1);
        chk("R7 rdata idle", rdata, 32'h0);

        // R1 loads and readback
        cur_tag = "R1";
        step(1'b1, 1'b0, 8'h10, 32'd5);
        step(1'b1, 1'b0, 8'h14, 32'd9);
        step(1'b1, 1'b0, 8'h18, 32'd3);
        step(1'b1, 1'b0, 8'h1C, 32'd20);
        step(1'b0, 1'b1, 8'h14, 32'h0);
        chk("R1 reload readback", rdata, 32'd9);

        // R2 R6 R8: run all, enable irq for timers 1 and 2
        cur_tag = "R8";
        step(1'b1, 1'b0, 8'h00, 32'h0000_003F);
        for (int k = 0; k < 30; k++) begin
            if (k % 5 == 0) step(1'b0, 1'b1, 8'(32 + 4 * (k % 4)), 32'h0);
            else idle(1);
        end
        cur_tag = "R2";
        step(1'b0, 1'b1, 8'h00, 32'h0);

        // R3 clear by address with arbitrary data, timers stopped
        cur_tag = "R3";
        step(1'b1, 1'b0, 8'h00, 32'h0000_0F30);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R2 all flags set", {28'b0, rdata[11:8]}, 32'hF);
        step(1'b1, 1'b0, 8'h30, 32'hDEAD_BEEF);
        step(1'b1, 1'b0, 8'h38, 32'hFFFF_FFFF);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R3 flags after address clears", {28'b0, rdata[11:8]}, 32'hA);

        // R4 write zero clears, write one keeps and never sets
        cur_tag = "R4";
        step(1'b1, 1'b0, 8'h00, 32'h0000_0730);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R4 write zero clears timer 4", {28'b0, rdata[11:8]}, 32'h2);
        step(1'b1, 1'b0, 8'h00, 32'h0000_0D30);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R4 write one no set", {28'b0, rdata[11:8]}, 32'h0);

        // R6 gating: flags set but enables off
        cur_tag = "R6";
        step(1'b1, 1'b0, 8'h00, 32'h0000_000F);
        idle(25);
        step(1'b1, 1'b0, 8'h00, 32'h0000_0F30);
        chk("R6 irq enabled flag", {31'b0, irq}, 32'h1);

        // R10 clear addresses read zero
        cur_tag = "R10";
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 1'b1, 8'(48 + 4 * i), 32'h0);
            chk("R10 clear read", rdata, 32'h0);
        end

        // R5 expiry and address clear on the same edge
        cur_tag = "R5";
        step(1'b1, 1'b0, 8'h00, 32'h0000_0011);
        step(1'b1, 1'b0, 8'h10, 32'd4);
        while (m_cnt[0] != 32'd1) idle(1);
        step(1'b1, 1'b0, 8'h30, 32'h0);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R5 address clear loses", {31'b0, rdata[8]}, 32'h1);
        while (m_cnt[0] != 32'd1) idle(1);
        step(1'b1, 1'b0, 8'h00, 32'h0000_0011);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R5 status clear loses", {31'b0, rdata[8]}, 32'h1);
        chk("R5 irq stays", {31'b0, irq}, 32'h1);

        // R9 snapshot mode
        cur_tag = "R9";
        step(1'b1, 1'b0, 8'h00, 32'h0001_000F);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        idle(3);
        step(1'b0, 1'b1, 8'h2C, 32'h0);
        begin
            logic [31:0] first;
            first = rdata;
            idle(4);
            step(1'b0, 1'b1, 8'h2C, 32'h0);
            chk("R9 snapshot holds", rdata, first);
        end
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'(32 + 4 * i), 32'h0);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 8'(32 + 4 * i), 32'h0);

        // R11 zero reload: timer 3 parks at zero without expiring
        cur_tag = "R11";
        step(1'b1, 1'b0, 8'h00, 32'h0000_0000);
        step(1'b1, 1'b0, 8'h18, 32'd0);
        step(1'b1, 1'b0, 8'h00, 32'h0000_0004);
        idle(10);
        step(1'b0, 1'b1, 8'h28, 32'h0);
        chk("R11 count parked", rdata, 32'h0);
        step(1'b0, 1'b1, 8'h00, 32'h0);
        chk("R11 no expiry", {31'b0, rdata[10]}, 32'h0);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule